// File: doc/BRIEF.md
# Tagged Operand-Select Adder ALU

This block is the arithmetic unit of a small CPU whose 8-bit words carry a tag in their top bit and a 7-bit payload below it. A single 8-bit adder, fed through two operand selectors, produces every result the CPU needs from its value register V: a copy, plus one, minus one, minus two, an argument-counter update and a source-index offset for argument binding. The A operand is one of zero, the low nibble of the argument counter, the constant -2, or the source index. The B operand is either V itself or a padded offset whose upper six bits are ones and whose two low bits come from V.

Two results leave the block. The raw sum goes to the register side for argument binding. The bus word replaces the top bit of the sum with the tag bit of the incoming V, so increments and decrements never leak into the tag. The carry out of the adder is also brought out for observation and affects neither result. All three outputs are registered, and a synchronous active-high reset clears them.

Top module: `tagged_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_q`, `bus_q` and `cout_q` become 0 after that edge.
- R2: With `op_sel` = 2'b00 the adder computes 0 + V + `cin`: V when `cin` is 0, V+1 (mod 256) when `cin` is 1.
- R3: With `op_sel` = 2'b10 the adder computes 8'hFE + V + `cin` (mod 256): V-2 when `cin` is 0, V-1 when `cin` is 1.
- R4: With `op_sel` = 2'b01 the A operand is `ac_in[3:0]` zero-extended to 8 bits and B is {6'b111111, V[1:0]}; bits 7..4 of `ac_in` have no effect on any output.
- R5: With `op_sel` = 2'b11 the A operand is `si_in` and B is {6'b111111, V[1:0]}; with `cin` = 1 the sum is simply one greater, with no special case.
- R6: `bus_q` equals {V[7], sum[6:0]}, where V[7] is bit 7 of the `v_in` applied with the same operation.
- R7: `cout_q` is bit 8 of the 9-bit sum A + B + `cin`.
- R8: Every output reflects the inputs sampled at the previous rising edge: one clock of latency, with a new operation accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | Operand selector: 00 zero/V, 01 counter/padded V, 10 minus-two/V, 11 source index/padded V |
| cin | input | 1 | Carry into the adder |
| v_in | input | 8 | Value register V |
| ac_in | input | 8 | Argument counter; only bits 3..0 are used |
| si_in | input | 8 | Source index |
| sum_q | output | 8 | Registered full 8-bit sum |
| bus_q | output | 8 | Registered bus word: tag of V over sum bits 6..0 |
| cout_q | output | 1 | Registered carry out of the adder |

## Verification
Each of the three results is due exactly one rising edge after its operands are driven, since a single register stage sits between the inputs and the ports. The driver applies operands on the falling edge and queues the expected sum, bus word and carry; the monitor wakes one nanosecond after the next rising edge, pops one entry and compares, so every comparison lands on the cycle the result is due and a lost or extra cycle of latency shows as a miscompare. The sweep covers every V value under every selector and carry, with random counter and index values whose upper counter bits are often set, then a mid-run reset.

// File: rtl/tagged_alu_pkg.sv
package tagged_alu_pkg;
  typedef enum logic [1:0] {
    SEL_ZERO_V   = 2'b00,
    SEL_CNT_PAD  = 2'b01,
    SEL_MTWO_V   = 2'b10,
    SEL_SIDX_PAD = 2'b11
  } op_sel_e;
endpackage

// File: rtl/alu_opa_mux.sv
module alu_opa_mux #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] sidx,
  output logic [DATA_W-1:0] opa
);
  import tagged_alu_pkg::*;
  localparam logic [DATA_W-1:0] MINUS_TWO = ~DATA_W'(1);
  localparam int CNT_HI = DATA_W - CNT_W;

  logic [DATA_W-1:0] cnt_ext;

  generate
    if (CNT_HI > 0) begin : g_cnt_pad
      assign cnt_ext = {{CNT_HI{1'b0}}, cnt[CNT_W-1:0]};
    end else begin : g_cnt_full
      assign cnt_ext = cnt;
    end
  endgenerate

  always_comb begin
    unique case (op_sel_e'(sel))
      SEL_ZERO_V:   opa = '0;
      SEL_CNT_PAD:  opa = cnt_ext;
      SEL_MTWO_V:   opa = MINUS_TWO;
      SEL_SIDX_PAD: opa = sidx;
      default:      opa = '0;
    endcase
  end
endmodule

// File: rtl/alu_opb_pad.sv
module alu_opb_pad #(
  parameter int DATA_W   = 8,
  parameter int PAD_BITS = 2
) (
  input  logic              use_pad,
  input  logic [DATA_W-1:0] v,
  output logic [DATA_W-1:0] opb
);
  localparam int ONES_W = DATA_W - PAD_BITS;

  logic [DATA_W-1:0] padded;
  assign padded = {{ONES_W{1'b1}}, v[PAD_BITS-1:0]};
  assign opb    = use_pad ? padded : v;
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              ci,
  output logic [DATA_W-1:0] s,
  output logic              co
);
  logic [DATA_W:0] wide;
  assign wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
  assign s    = wide[DATA_W-1:0];
  assign co   = wide[DATA_W];
endmodule

// File: rtl/tagged_alu.sv
module tagged_alu #(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 4,
  parameter int PAD_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_sel,
  input  logic              cin,
  input  logic [DATA_W-1:0] v_in,
  input  logic [DATA_W-1:0] ac_in,
  input  logic [DATA_W-1:0] si_in,
  output logic [DATA_W-1:0] sum_q,
  output logic [DATA_W-1:0] bus_q,
  output logic              cout_q
);
  localparam int TAG = DATA_W - 1;

  logic [DATA_W-1:0] opa, opb, sum_d;
  logic              cout_d;

  alu_opa_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_opa (
    .sel(op_sel), .cnt(ac_in), .sidx(si_in), .opa(opa)
  );

  alu_opb_pad #(.DATA_W(DATA_W), .PAD_BITS(PAD_BITS)) u_opb (
    .use_pad(op_sel[0]), .v(v_in), .opb(opb)
  );

  alu_adder #(.DATA_W(DATA_W)) u_add (
    .a(opa), .b(opb), .ci(cin), .s(sum_d), .co(cout_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      bus_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      bus_q  <= {v_in[TAG], sum_d[TAG-1:0]};
      cout_q <= cout_d;
    end
  end

  // R2: copy and increment of V, one cycle later (R8)
  p_copy_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b00) |=> (sum_q == $past(v_in) + DATA_W'($past(cin))));

  // R3: minus-two and decrement of V
  p_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b10 && cin) |=> (sum_q == $past(v_in) - DATA_W'(1)));

  // R4: counter path sees only the low nibble, whatever its upper bits
  p_cnt_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b01 && v_in[1:0] == 2'b11 && !cin) |=>
      (sum_q == DATA_W'($past(ac_in[CNT_W-1:0])) - DATA_W'(1)));

  // R6: tag bit of the bus word follows the V that produced it
  p_bus_tag_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bus_q[TAG] == $past(v_in[TAG])));

  // R6: payload bits of the bus word match the full sum
  p_bus_low_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bus_q[TAG-1:0] == sum_q[TAG-1:0]));

  // R7: adding zero to V never carries
  p_no_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b00 && v_in != '1) |=> !cout_q);
endmodule

// File: tb/tagged_alu_tb_top.sv
`timescale 1ns/1ps
module tagged_alu_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   op_sel;
  logic         cin;
  logic [W-1:0] v_in, ac_in, si_in;
  logic [W-1:0] sum_q, bus_q;
  logic         cout_q;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [W-1:0] sum;
    logic [W-1:0] bus;
    logic         co;
    string        tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  tagged_alu dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .cin(cin),
    .v_in(v_in), .ac_in(ac_in), .si_in(si_in),
    .sum_q(sum_q), .bus_q(bus_q), .cout_q(cout_q)
  );

  function automatic exp_t model(input logic [1:0] s, input logic c,
                                 input logic [W-1:0] v, input logic [W-1:0] ac,
                                 input logic [W-1:0] si);
    exp_t e;
    logic [W-1:0] a, b;
    logic [W:0]   t;
    b = s[0] ? {6'b111111, v[1:0]} : v;
    case (s)
      2'b00: begin a = 8'h00;           e.tag = "R2"; end
      2'b01: begin a = {4'h0, ac[3:0]}; e.tag = "R4"; end
      2'b10: begin a = 8'hFE;           e.tag = "R3"; end
      default: begin a = si;            e.tag = "R5"; end
    endcase
    t     = {1'b0, a} + {1'b0, b} + {8'h00, c};
    e.sum = t[W-1:0];
    e.bus = {v[7], t[6:0]};
    e.co  = t[W];
    return e;
  endfunction

  task automatic drive(input logic [1:0] s, input logic c, input logic [W-1:0] v,
                       input logic [W-1:0] ac, input logic [W-1:0] si);
    @(negedge clk);
    op_sel = s; cin = c; v_in = v; ac_in = ac; si_in = si;
    sb.push_back(model(s, c, v, ac, si));
  endtask

  // Monitor: result due one rising edge after operands are driven (R8)
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (sum_q !== e.sum) begin
        n_fail++;
        $display("FAIL %s R8 sum: got %h exp %h (sel=%b)", e.tag, sum_q, e.sum, op_sel);
      end
      if (bus_q !== e.bus) begin
        n_fail++;
        $display("FAIL R6 bus: got %h exp %h", bus_q, e.bus);
      end
      if (cout_q !== e.co) begin
        n_fail++;
        $display("FAIL R7 cout: got %b exp %b", cout_q, e.co);
      end
    end
  end

  task automatic check_reset(input string when);
    n_vec++;
    if (sum_q !== '0 || bus_q !== '0 || cout_q !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset %s: got sum=%h bus=%h co=%b exp 00 00 0",
               when, sum_q, bus_q, cout_q);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    rst = 1'b1; op_sel = 2'b00; cin = 1'b0;
    v_in = 8'hA5; ac_in = 8'hFF; si_in = 8'h3C;
    repeat (3) @(posedge clk);
    #1 check_reset("start");
    @(negedge clk) rst = 1'b0;

    // Directed corners
    drive(2'b00, 1'b0, 8'h7F, 8'h00, 8'h00);  // R2 copy
    drive(2'b00, 1'b1, 8'h7F, 8'h00, 8'h00);  // R2 inc, tag kept 0 (R6)
    drive(2'b00, 1'b1, 8'hFF, 8'h00, 8'h00);  // R7 carry from FF+1
    drive(2'b10, 1'b0, 8'h80, 8'h00, 8'h00);  // R3 tag 1, payload wraps
    drive(2'b10, 1'b1, 8'h00, 8'h00, 8'h00);  // R3 decrement of zero
    drive(2'b01, 1'b0, 8'h03, 8'hF5, 8'h00);  // R4 upper AC bits ignored
    drive(2'b01, 1'b0, 8'h03, 8'h05, 8'h00);  // R4 same result with clean AC
    drive(2'b01, 1'b1, 8'h00, 8'h0F, 8'h00);  // R4 unused combo, plain +1
    drive(2'b11, 1'b0, 8'h02, 8'h00, 8'h40);  // R5 binding
    drive(2'b11, 1'b1, 8'h02, 8'h00, 8'h40);  // R5 unused combo, plain +1

    // Full sweep
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int v = 0; v < 256; v++)
          drive(2'(s), 1'(c), 8'(v), 8'($urandom), 8'($urandom));

    @(negedge clk);
    while (sb.size() > 0) @(negedge clk);

    // Mid-run reset with live operands
    op_sel = 2'b11; cin = 1'b1; v_in = 8'hFF; ac_in = 8'hFF; si_in = 8'hFF;
    rst = 1'b1;
    @(posedge clk); #1 check_reset("mid-run");
    @(negedge clk) rst = 1'b0;
    drive(2'b10, 1'b0, 8'h01, 8'h00, 8'h00);  // R3 after reset: FF, carry 0
    @(negedge clk);
    while (sb.size() > 0) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang exp completion");
      summary();
      $finish;
    end
  end
endmodule